// File: doc/BRIEF.md
# Shifter Operand Unit with Carry-Out

This block forms the second operand of an integer ALU. It takes a data word, a two-bit shift kind, a shift amount, a mode select and the current carry flag. It returns the shifted word and the carry that the shift produces. The data path is one logarithmic barrel shifter shared by both modes. A small selection stage after it applies the amount-zero and out-of-range rules. The immediate mode and the register mode have different rules for these cases.

In immediate mode the amount is a short field taken from the low bits of the amount input. A zero in that field does not mean "no shift" for the right shifts and the rotate: it means a full-width shift, or a one-bit rotate through the carry. In register mode the amount is a whole byte. Zero there means "no operation, keep the carry", and amounts of one data width or more saturate.

An output register stage can be kept or dropped with a parameter. By default it is kept, which adds one clock of latency.

Top module: `shop_unit`

## Requirements
- R1: The kind input selects 0 = shift left, 1 = logical shift right, 2 = arithmetic shift right, 3 = rotate right. The mode input selects 0 = immediate and 1 = register. For an effective amount n with 0 < n < 32, the result is the shifted or rotated word. The carry is data bit (32−n) for the left shift and data bit (n−1) for the other three kinds.
- R2: In immediate mode only amount bits [4:0] are used. Amount bits [7:5] have no effect on the result or on the carry.
- R3: Immediate mode, left shift, amount field zero: the result equals the data and the carry equals the carry input.
- R4: Immediate mode, logical right shift, amount field zero: the word is shifted by 32. The result is zero and the carry is data bit 31.
- R5: Immediate mode, arithmetic right shift, amount field zero: every result bit equals data bit 31, and the carry is data bit 31.
- R6: Immediate mode, rotate, amount field zero: the word is rotated one place through the carry. The result is {carry input, data[31:1]} and the carry is data bit 0.
- R7: Register mode, amount byte zero: for every kind, the result equals the data and the carry equals the carry input.
- R8: Register mode, left or logical right shift by 32 or more gives a zero result. At exactly 32 the carry is data bit 0 for the left shift and data bit 31 for the right shift. Above 32 the carry is 0.
- R9: Register mode, arithmetic right shift by 32 or more: every result bit equals data bit 31, and the carry is data bit 31.
- R10: Register mode, rotate: the rotate amount is amount bits [4:0]. A nonzero amount whose low five bits are zero leaves the word unchanged and gives data bit 31 as the carry.
- R11: With the default output stage, the result and carry appear one clock after the inputs. While reset (active low) is asserted, both outputs read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 32 | Word to be shifted |
| kind_i | input | 2 | Shift kind (0 left, 1 logical right, 2 arithmetic right, 3 rotate) |
| reg_mode_i | input | 1 | 0 = immediate amount, 1 = register amount |
| amount_i | input | 8 | Shift amount |
| carry_i | input | 1 | Current carry flag |
| result_o | output | 32 | Shifted word |
| carry_o | output | 1 | Shifter carry-out |

## Verification
In one cycle, both the shared barrel and a corner-case override can claim the outputs. This happens when the amount's low five bits are zero while its upper bits are set. In immediate mode the barrel's no-op result must then give way to the zero-field rule. In register mode the barrel's no-op result must give way to the saturation or rotate-by-multiple rule. The bench provokes this by sweeping every amount byte from 0 to 255 for every kind, both modes and both carry inputs. It judges each output against a reference computed from shift arithmetic on the requirements, one clock after the inputs are applied.

// File: rtl/shop_pkg.sv
package shop_pkg;

   typedef enum logic [1:0] {
      SHK_LSL = 2'd0,
      SHK_LSR = 2'd1,
      SHK_ASR = 2'd2,
      SHK_ROR = 2'd3
   } shift_kind_e;

endpackage

// File: rtl/shop_barrel.sv
module shop_barrel
   import shop_pkg::*;
#(
   parameter int DATA_W = 32,
   localparam int SH_W = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  shift_kind_e       kind,
   input  logic [SH_W-1:0]   amt,
   output logic [DATA_W-1:0] dout,
   output logic              cout
);

   logic [DATA_W-1:0] stg [0:SH_W];
   assign stg[0] = din;

   for (genvar s = 0; s < SH_W; s++) begin : g_stage
      localparam int D = 1 << s;
      logic [DATA_W-1:0] moved;
      always_comb begin
         unique case (kind)
            SHK_LSL: moved = {stg[s][DATA_W-1-D:0], {D{1'b0}}};
            SHK_LSR: moved = {{D{1'b0}}, stg[s][DATA_W-1:D]};
            SHK_ASR: moved = {{D{stg[s][DATA_W-1]}}, stg[s][DATA_W-1:D]};
            default: moved = {stg[s][D-1:0], stg[s][DATA_W-1:D]};
         endcase
      end
      assign stg[s+1] = amt[s] ? moved : stg[s];
   end

   assign dout = stg[SH_W];

   // last bit leaving the word
   logic [SH_W:0]   idx_left;
   logic [SH_W-1:0] idx_right;
   assign idx_left  = (SH_W+1)'(DATA_W) - {1'b0, amt};
   assign idx_right = amt - SH_W'(1);

   always_comb begin
      if (amt == '0)
         cout = 1'b0;
      else if (kind == SHK_LSL)
         cout = din[idx_left[SH_W-1:0]];
      else
         cout = din[idx_right];
   end

endmodule

// File: rtl/shop_select.sv
module shop_select
   import shop_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int AMT_W  = 8,
   localparam int SH_W  = $clog2(DATA_W)
) (
   input  logic [DATA_W-1:0] din,
   input  logic              cin,
   input  shift_kind_e       kind,
   input  logic              reg_mode,
   input  logic [AMT_W-1:0]  amt,
   input  logic [DATA_W-1:0] bar_res,
   input  logic              bar_c,
   output logic [DATA_W-1:0] res,
   output logic              cout
);

   logic low_zero, far, exact, msb;
   logic [DATA_W-1:0] fill;

   assign low_zero = (amt[SH_W-1:0] == '0);
   assign far      = |amt[AMT_W-1:SH_W];
   assign exact    = (amt == AMT_W'(DATA_W));
   assign msb      = din[DATA_W-1];
   assign fill     = {DATA_W{msb}};

   always_comb begin
      res  = bar_res;
      cout = bar_c;
      if (!reg_mode) begin
         if (low_zero) begin
            unique case (kind)
               SHK_LSL: begin res = din;                     cout = cin;    end
               SHK_LSR: begin res = '0;                      cout = msb;    end
               SHK_ASR: begin res = fill;                    cout = msb;    end
               default: begin res = {cin, din[DATA_W-1:1]};  cout = din[0]; end
            endcase
         end
      end else if (amt == '0) begin
         res  = din;
         cout = cin;
      end else begin
         unique case (kind)
            SHK_LSL, SHK_LSR: begin
               if (far) begin
                  res  = '0;
                  cout = exact ? ((kind == SHK_LSL) ? din[0] : msb) : 1'b0;
               end
            end
            SHK_ASR: begin
               if (far) begin
                  res  = fill;
                  cout = msb;
               end
            end
            default: begin
               if (low_zero) begin
                  res  = din;
                  cout = msb;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/shop_out_stage.sv
module shop_out_stage #(
   parameter int DATA_W  = 32,
   parameter bit OUT_REG = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] d_res,
   input  logic              d_c,
   output logic [DATA_W-1:0] q_res,
   output logic              q_c
);

   if (OUT_REG) begin : g_flop
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            q_res <= '0;
            q_c   <= 1'b0;
         end else begin
            q_res <= d_res;
            q_c   <= d_c;
         end
      end
   end else begin : g_wire
      assign q_res = d_res;
      assign q_c   = d_c;
   end

endmodule

// File: rtl/shop_unit.sv
module shop_unit
   import shop_pkg::*;
#(
   parameter int DATA_W  = 32,
   parameter int AMT_W   = 8,
   parameter bit OUT_REG = 1'b1,
   localparam int SH_W   = $clog2(DATA_W)
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [DATA_W-1:0] data_i,
   input  logic [1:0]        kind_i,
   input  logic              reg_mode_i,
   input  logic [AMT_W-1:0]  amount_i,
   input  logic              carry_i,
   output logic [DATA_W-1:0] result_o,
   output logic              carry_o
);

   if (DATA_W < 8 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_width
      $error("shop_unit: DATA_W must be a power of two, at least 8");
   end
   if (AMT_W <= SH_W) begin : g_bad_amt
      $error("shop_unit: AMT_W must exceed log2(DATA_W)");
   end

   shift_kind_e       kind;
   logic [DATA_W-1:0] bar_res, sel_res;
   logic              bar_c, sel_c;

   assign kind = shift_kind_e'(kind_i);

   shop_barrel #(.DATA_W(DATA_W)) u_barrel (
      .din  (data_i),
      .kind (kind),
      .amt  (amount_i[SH_W-1:0]),
      .dout (bar_res),
      .cout (bar_c)
   );

   shop_select #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_select (
      .din      (data_i),
      .cin      (carry_i),
      .kind     (kind),
      .reg_mode (reg_mode_i),
      .amt      (amount_i),
      .bar_res  (bar_res),
      .bar_c    (bar_c),
      .res      (sel_res),
      .cout     (sel_c)
   );

   shop_out_stage #(.DATA_W(DATA_W), .OUT_REG(OUT_REG)) u_out (
      .clk   (clk_i),
      .rst_n (rst_ni),
      .d_res (sel_res),
      .d_c   (sel_c),
      .q_res (result_o),
      .q_c   (carry_o)
   );

   AST_REG_ZERO_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_mode_i && amount_i == '0) |-> (sel_res == data_i && sel_c == carry_i)); // R7

   AST_FAR_SHIFT_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_mode_i && (kind_i == 2'd0 || kind_i == 2'd1) && amount_i > AMT_W'(DATA_W))
      |-> (sel_res == '0 && !sel_c)); // R8

   AST_SIGN_FILL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (kind_i == 2'd2 && ((reg_mode_i && amount_i >= AMT_W'(DATA_W)) ||
                          (!reg_mode_i && amount_i[SH_W-1:0] == '0)))
      |-> (sel_res == {DATA_W{data_i[DATA_W-1]}} && sel_c == data_i[DATA_W-1])); // R5

   AST_RRX_FORM: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!reg_mode_i && kind_i == 2'd3 && amount_i[SH_W-1:0] == '0)
      |-> (sel_res == {carry_i, data_i[DATA_W-1:1]} && sel_c == data_i[0])); // R6

   AST_ROR_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (reg_mode_i && kind_i == 2'd3 && amount_i != '0 && amount_i[SH_W-1:0] == '0)
      |-> (sel_res == data_i && sel_c == data_i[DATA_W-1])); // R10

   if (OUT_REG) begin : g_lat_chk
      logic primed;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) primed <= 1'b0;
         else         primed <= 1'b1;
      end
      AST_STAGE_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
         primed |-> (result_o == $past(sel_res) && carry_o == $past(sel_c))); // R11
   end

endmodule

// File: tb/shop_unit_tb.sv
module shop_unit_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] data = '0;
   logic [1:0]  kind = '0;
   logic        mode = 1'b0;
   logic [7:0]  amount = '0;
   logic        cin = 1'b0;
   logic [31:0] result;
   logic        cout;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   shop_unit u_dut (
      .clk_i      (clk),
      .rst_ni     (rst_n),
      .data_i     (data),
      .kind_i     (kind),
      .reg_mode_i (mode),
      .amount_i   (amount),
      .carry_i    (cin),
      .result_o   (result),
      .carry_o    (cout)
   );

   function automatic void ref_model(input logic [31:0] a, input logic [1:0] t,
                                     input logic md, input logic [7:0] amt,
                                     input logic ci, output logic [31:0] r,
                                     output logic c);
      int n;
      if (!md) begin
         n = int'(amt[4:0]);
         case (t)
            2'd0: if (n == 0) begin r = a; c = ci; end
                  else begin r = a << n; c = a[32-n]; end
            2'd1: if (n == 0) begin r = '0; c = a[31]; end
                  else begin r = a >> n; c = a[n-1]; end
            2'd2: if (n == 0) begin r = {32{a[31]}}; c = a[31]; end
                  else begin r = $unsigned($signed(a) >>> n); c = a[n-1]; end
            default: if (n == 0) begin r = {ci, a[31:1]}; c = a[0]; end
                  else begin r = (a >> n) | (a << (32 - n)); c = a[n-1]; end
         endcase
      end else begin
         n = int'(amt);
         if (n == 0) begin r = a; c = ci; end
         else case (t)
            2'd0: if (n < 32) begin r = a << n; c = a[32-n]; end
                  else begin r = '0; c = (n == 32) ? a[0] : 1'b0; end
            2'd1: if (n < 32) begin r = a >> n; c = a[n-1]; end
                  else begin r = '0; c = (n == 32) ? a[31] : 1'b0; end
            2'd2: if (n < 32) begin r = $unsigned($signed(a) >>> n); c = a[n-1]; end
                  else begin r = {32{a[31]}}; c = a[31]; end
            default: begin
               n = n % 32;
               if (n == 0) begin r = a; c = a[31]; end
               else begin r = (a >> n) | (a << (32 - n)); c = a[n-1]; end
            end
         endcase
      end
   endfunction

   function automatic string tag_of(input logic [1:0] t, input logic md, input logic [7:0] amt);
      if (!md) begin
         if (amt[4:0] == 5'd0) begin
            case (t)
               2'd0: return "R3";
               2'd1: return "R4";
               2'd2: return "R5";
               default: return "R6";
            endcase
         end
         return (amt[7:5] != 3'd0) ? "R2" : "R1";
      end
      if (amt == 8'd0) return "R7";
      if (t == 2'd3) return "R10";
      if (amt >= 8'd32) return (t == 2'd2) ? "R9" : "R8";
      return "R1";
   endfunction

   task automatic apply_and_check(input logic [31:0] a, input logic [1:0] t,
                                  input logic md, input logic [7:0] amt, input logic ci);
      logic [31:0] er;
      logic        ec;
      data = a; kind = t; mode = md; amount = amt; cin = ci;
      ref_model(a, t, md, amt, ci, er, ec);
      @(negedge clk);   // one register stage: value captured at the posedge between (R11)
      checks++;
      if (result !== er || cout !== ec) begin
         errors++;
         $display("FAIL %s kind=%0d mode=%0d amt=%0d data=%h cin=%0b: got %h/%0b expected %h/%0b",
                  tag_of(t, md, amt), t, md, amt, a, ci, result, cout, er, ec);
      end
   endtask

   initial begin
      logic [31:0] pats [4];
      pats[0] = 32'h8000_0001;
      pats[1] = 32'h7FFF_FFFE;
      pats[2] = 32'hA5C3_3C5A;
      pats[3] = 32'h1234_5679;

      // R11: outputs are zero while reset is held
      data = 32'hFFFF_FFFF; amount = 8'd0; mode = 1'b1; cin = 1'b1;
      repeat (3) @(negedge clk);
      checks++;
      if (result !== 32'd0 || cout !== 1'b0) begin
         errors++;
         $display("FAIL R11 reset state: got %h/%0b expected 00000000/0", result, cout);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R1..R10: full amount sweep, all kinds, both modes, both carry inputs
      for (int p = 0; p < 4; p++)
         for (int md = 0; md < 2; md++)
            for (int t = 0; t < 4; t++)
               for (int ci = 0; ci < 2; ci++)
                  for (int am = 0; am < 256; am++)
                     apply_and_check(pats[p], 2'(t), 1'(md), 8'(am), 1'(ci));

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      if (!done) begin
         errors++;
         $display("FAIL R11 watchdog expired before the sweep ended");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule